// File: doc/BRIEF.md
# MII Collision and Carrier-Sense Generator

This block drives the collision (`col`) and carrier-sense (`crs`) status lines that a 10/100 Ethernet PHY presents to its MAC or repeater. It first works out whether the line is receiving. At 10 Mb/s it takes this from an unsquelched receive-activity flag. At 100 Mb/s it examines each 10-bit receive symbol, one per valid strobe. Activity starts on a symbol that holds two zeros with at least one bit between them, and ends on an all-ones idle symbol.

Collision is flagged when transmit and receive overlap in half duplex, and is forced low in full duplex. Carrier sense follows receive activity alone in full-duplex or repeater operation. In plain half duplex it also follows transmit enable. At 10 Mb/s half duplex, a heartbeat (SQE test) pulse appears on `col` a set number of cycles after each transmission ends, unless a control input inhibits it.

Both outputs are registered in the block's own clock domain. A MAC must treat them as asynchronous to its transmit and receive clocks. The mode controls arrive as plain static inputs.

Top module: `mii_status_gen`

## Requirements
- R1: While `rst_n` is low, `col` and `crs` read 0 at the next clock edge, and 100 Mb/s activity and the SQE timer are cleared.
- R2: In half duplex, `col` is 1 one clock after any cycle in which `tx_en` and receive activity are both 1, and 0 when either is 0 (outside an SQE pulse).
- R3: When `speed_100`=0, receive activity equals `rx10_act`. When `speed_100`=1, `rx10_act` has no effect.
- R4: When `speed_100`=1, a strobed symbol (`sym_valid`=1) with two 0 bits at positions i and j, where |i-j|>=2, sets 100 Mb/s activity. This shows on `col`/`crs` two clocks after the strobe.
- R5: A strobed symbol with no 0 bit, one 0 bit, or exactly two 0 bits in adjacent positions leaves the activity state unchanged, except for the all-ones case in R6.
- R6: A strobed symbol equal to 10'h3FF clears 100 Mb/s activity.
- R7: When `full_duplex`=1, `col` stays 0 one clock later, whatever the other inputs are.
- R8: With `full_duplex`=0 and `repeater_mode`=0, `crs` equals (receive activity OR `tx_en`) from the previous cycle.
- R9: With `full_duplex`=1 or `repeater_mode`=1, `crs` equals receive activity from the previous cycle, regardless of `tx_en`.
- R10: With `speed_100`=0, `full_duplex`=0 and `sqe_inhibit`=0, a falling edge of `tx_en` seen at clock edge E0 makes `col` 1 after edges E(SQE_DELAY+1) through E(SQE_DELAY+SQE_LEN) inclusive, and 0 elsewhere in that window.
- R11: With `sqe_inhibit`=1, no SQE pulse appears on `col` after a `tx_en` falling edge.
- R12: With `speed_100`=1 or `full_duplex`=1, no SQE pulse appears after a `tx_en` falling edge.
- R13: A symbol presented with `sym_valid`=0 has no effect on activity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tx_en | input | 1 | Transmit enable from the MAC |
| rx10_act | input | 1 | Unsquelched receive activity at 10 Mb/s |
| sym_valid | input | 1 | Strobe for `sym_data` |
| sym_data | input | SYM_W | Received 10-bit symbol at 100 Mb/s |
| speed_100 | input | 1 | 1 = 100 Mb/s, 0 = 10 Mb/s |
| full_duplex | input | 1 | 1 = full duplex |
| repeater_mode | input | 1 | 1 = repeater operation |
| sqe_inhibit | input | 1 | 1 = suppress SQE test pulse |
| col | output | 1 | Collision / SQE status |
| crs | output | 1 | Carrier sense |

## Verification
The bench sweeps all 1024 symbol values twice: once from an idle state and once from an active state. A detector that counted any two zeros would flag activity on adjacent-only pairs. A detector that failed to latch would drop activity on neutral symbols. The bench also walks every combination of duplex, repeater, transmit and receive, which catches carrier sense taking transmit in the wrong mode. Finally, it checks the SQE pulse cycle by cycle, so a pulse that is off by one cycle at either end, or that fires under inhibit, at 100 Mb/s or in full duplex, is reported.

// File: rtl/mii_status_pkg.sv
// Shared types for the MII status generator.
package mii_status_pkg;
    typedef enum logic [1:0] {
        SQE_IDLE  = 2'd0,
        SQE_WAIT  = 2'd1,
        SQE_PULSE = 2'd2
    } sqe_state_t;
endpackage

// File: rtl/mii_sym_detect.sv
// Detects 100 Mb/s receive activity from 10-bit symbols.
// Assumes one symbol per sym_valid strobe, already aligned.
// Activity sets on any two zeros at least two positions apart and
// clears on an all-ones symbol; every other symbol holds the state.
module mii_sym_detect #(
    parameter int SYM_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sym_valid,
    input  logic [SYM_W-1:0] sym_data,
    output logic             act100
);
    localparam int PAIR_N = SYM_W - 2;

    logic [PAIR_N-1:0] far_zero;
    logic              qualify;
    logic              idle_sym;

    // For each low position, flag a zero paired with a zero two or more bits above.
    for (genvar i = 0; i < PAIR_N; i++) begin : g_pair
        assign far_zero[i] = ~sym_data[i] & (~sym_data[SYM_W-1:i+2] != '0);
    end

    // Summarise the symbol into set / clear terms.
    always_comb begin
        qualify  = |far_zero;
        idle_sym = &sym_data;
    end

    // Hold activity from a qualifying symbol until an idle symbol.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act100 <= 1'b0;
        end else if (sym_valid) begin
            if (qualify)       act100 <= 1'b1;
            else if (idle_sym) act100 <= 1'b0;
        end
    end
endmodule

// File: rtl/mii_sqe_timer.sv
// Generates the SQE test window after each transmission.
// Assumes 10 Mb/s half duplex is the only mode that wants it.
// A tx_en fall starts a delay of DELAY cycles and then a pulse of LEN
// cycles. Transmit restart, mode change or inhibit aborts the window.
module mii_sqe_timer
    import mii_status_pkg::*;
#(
    parameter int DELAY = 200,
    parameter int LEN   = 200
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tx_en,
    input  logic enable,
    output logic sqe_on
);
    localparam int MAXC  = (DELAY > LEN) ? DELAY : LEN;
    localparam int CNT_W = $clog2(MAXC + 1);
    localparam logic [CNT_W-1:0] DLY_END = CNT_W'(DELAY - 1);
    localparam logic [CNT_W-1:0] LEN_END = CNT_W'(LEN - 1);

    sqe_state_t       state;
    logic [CNT_W-1:0] cnt;
    logic             tx_d;
    logic             tx_fall;

    // Remember transmit enable for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) tx_d <= 1'b0;
        else        tx_d <= tx_en;
    end

    // Falling edge of transmit enable.
    always_comb tx_fall = tx_d & ~tx_en;

    // Sequence idle, delay and pulse phases with one shared counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= SQE_IDLE;
            cnt   <= '0;
        end else if (!enable || tx_en) begin
            state <= SQE_IDLE;
            cnt   <= '0;
        end else begin
            unique case (state)
                SQE_IDLE: begin
                    if (tx_fall) begin
                        state <= SQE_WAIT;
                        cnt   <= '0;
                    end
                end
                SQE_WAIT: begin
                    if (cnt == DLY_END) begin
                        state <= SQE_PULSE;
                        cnt   <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                SQE_PULSE: begin
                    if (cnt == LEN_END) begin
                        state <= SQE_IDLE;
                        cnt   <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: begin
                    state <= SQE_IDLE;
                    cnt   <= '0;
                end
            endcase
        end
    end

    // Pulse output while in the pulse phase.
    always_comb sqe_on = (state == SQE_PULSE);
endmodule

// File: rtl/mii_status_out.sv
// Forms registered COL and CRS from activity terms and mode bits.
// Assumes mode bits are quasi-static; outputs lag inputs by one cycle.
module mii_status_out (
    input  logic clk,
    input  logic rst_n,
    input  logic speed_100,
    input  logic rx10_act,
    input  logic act100,
    input  logic tx_en,
    input  logic sqe_on,
    input  logic full_duplex,
    input  logic repeater_mode,
    output logic col,
    output logic crs
);
    logic rx_act;
    logic col_nxt;
    logic crs_nxt;

    // Select the receive-activity source by speed and build next values.
    always_comb begin
        rx_act  = speed_100 ? act100 : rx10_act;
        col_nxt = ~full_duplex & ((tx_en & rx_act) | sqe_on);
        crs_nxt = rx_act | (tx_en & ~full_duplex & ~repeater_mode);
    end

    // Register the status outputs so they never glitch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            col <= 1'b0;
            crs <= 1'b0;
        end else begin
            col <= col_nxt;
            crs <= crs_nxt;
        end
    end
endmodule

// File: rtl/mii_status_gen.sv
// Top level of the MII collision and carrier-sense generator.
// Assumes all inputs are synchronous to clk; col and crs are to be
// treated as asynchronous by any MAC-side clock domain.
module mii_status_gen #(
    parameter int SYM_W     = 10,
    parameter int SQE_DELAY = 200,
    parameter int SQE_LEN   = 200
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tx_en,
    input  logic             rx10_act,
    input  logic             sym_valid,
    input  logic [SYM_W-1:0] sym_data,
    input  logic             speed_100,
    input  logic             full_duplex,
    input  logic             repeater_mode,
    input  logic             sqe_inhibit,
    output logic             col,
    output logic             crs
);
    logic act100;
    logic sqe_on;
    logic sqe_en;

    // SQE test only in 10 Mb/s half duplex and when not inhibited.
    always_comb sqe_en = ~speed_100 & ~full_duplex & ~sqe_inhibit;

    mii_sym_detect #(.SYM_W(SYM_W)) u_sym (
        .clk       (clk),
        .rst_n     (rst_n),
        .sym_valid (sym_valid),
        .sym_data  (sym_data),
        .act100    (act100)
    );

    mii_sqe_timer #(.DELAY(SQE_DELAY), .LEN(SQE_LEN)) u_sqe (
        .clk    (clk),
        .rst_n  (rst_n),
        .tx_en  (tx_en),
        .enable (sqe_en),
        .sqe_on (sqe_on)
    );

    mii_status_out u_out (
        .clk           (clk),
        .rst_n         (rst_n),
        .speed_100     (speed_100),
        .rx10_act      (rx10_act),
        .act100        (act100),
        .tx_en         (tx_en),
        .sqe_on        (sqe_on),
        .full_duplex   (full_duplex),
        .repeater_mode (repeater_mode),
        .col           (col),
        .crs           (crs)
    );
endmodule

// File: rtl/mii_status_checker.sv
// Port-level properties of the MII status generator, bound to the top.
module mii_status_checker (
    input logic clk,
    input logic rst_n,
    input logic tx_en,
    input logic rx10_act,
    input logic speed_100,
    input logic full_duplex,
    input logic repeater_mode,
    input logic sqe_inhibit,
    input logic col,
    input logic crs
);
    logic [1:0] since_rst;

    // Count cycles since reset so two-deep history is only used when valid.
    always_ff @(posedge clk) begin
        if (!rst_n)              since_rst <= 2'd0;
        else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
    end

    AST_RESET_CLEAR: assert property (@(posedge clk)
        !$past(rst_n) && since_rst == 2'd0 |-> !col && !crs); // R1

    AST_FDX_COL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        since_rst != 2'd0 && $past(full_duplex) |-> !col); // R7

    AST_COL_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
        since_rst != 2'd0 && $past(!full_duplex && !speed_100 && tx_en && rx10_act) |-> col); // R2

    AST_CRS_HDX_TX: assert property (@(posedge clk) disable iff (!rst_n)
        since_rst != 2'd0 && $past(!full_duplex && !repeater_mode && tx_en) |-> crs); // R8

    AST_CRS_RX_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        since_rst != 2'd0 && $past((full_duplex || repeater_mode) && !speed_100 && !rx10_act) |-> !crs); // R9

    AST_SQE_INHIBIT: assert property (@(posedge clk) disable iff (!rst_n)
        since_rst >= 2'd2 && $past(sqe_inhibit) && $past(sqe_inhibit, 2) && !$past(tx_en) |-> !col); // R11
endmodule

bind mii_status_gen mii_status_checker u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .tx_en         (tx_en),
    .rx10_act      (rx10_act),
    .speed_100     (speed_100),
    .full_duplex   (full_duplex),
    .repeater_mode (repeater_mode),
    .sqe_inhibit   (sqe_inhibit),
    .col           (col),
    .crs           (crs)
);

// File: tb/mii_status_gen_bench.sv
// Self-checking bench: symbol sweeps, mode sweep and SQE window timing.
module mii_status_gen_bench;
    localparam int SW = 10;
    localparam int DL = 3;
    localparam int LN = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          tx_en = 1'b0;
    logic          rx10_act = 1'b0;
    logic          sym_valid = 1'b0;
    logic [SW-1:0] sym_data = '1;
    logic          speed_100 = 1'b0;
    logic          full_duplex = 1'b0;
    logic          repeater_mode = 1'b0;
    logic          sqe_inhibit = 1'b1;
    logic          col;
    logic          crs;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    mii_status_gen #(.SYM_W(SW), .SQE_DELAY(DL), .SQE_LEN(LN)) u_mii_status_gen (
        .clk (clk), .rst_n (rst_n), .tx_en (tx_en), .rx10_act (rx10_act),
        .sym_valid (sym_valid), .sym_data (sym_data), .speed_100 (speed_100),
        .full_duplex (full_duplex), .repeater_mode (repeater_mode),
        .sqe_inhibit (sqe_inhibit), .col (col), .crs (crs)
    );

    task automatic chk(input string req, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    // Present one strobed symbol for a single cycle.
    task automatic send(input logic [SW-1:0] s);
        @(negedge clk); sym_valid = 1'b1; sym_data = s;
        @(negedge clk); sym_valid = 1'b0;
    endtask

    // Arithmetic model: a non-adjacent zero pair exists.
    function automatic logic qual(input logic [SW-1:0] s);
        logic [SW-1:0] z = ~s;
        int nz = $countones(z);
        logic adj = ((z & (z >> 1)) != '0);
        return (nz >= 3) || (nz == 2 && !adj);
    endfunction

    // Drop tx_en and check col for each cycle of the SQE window.
    task automatic sqe_window(input string req, input logic expect_pulse);
        @(negedge clk); tx_en = 1'b1;
        repeat (3) @(negedge clk);
        tx_en = 1'b0;
        for (int k = 0; k <= DL + LN + 3; k++) begin
            @(negedge clk);
            chk(req, col, expect_pulse && k >= DL + 1 && k <= DL + LN);
        end
    endtask

    initial begin
        #1000000;
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        // R1: reset clears outputs even with active inputs.
        tx_en = 1'b1; rx10_act = 1'b1;
        repeat (3) @(negedge clk);
        chk("R1 col", col, 1'b0);
        chk("R1 crs", crs, 1'b0);
        tx_en = 1'b0; rx10_act = 1'b0;
        @(negedge clk); rst_n = 1'b1;

        // R2 R3 R7 R8 R9: sweep of 10 Mb/s mode and activity combinations.
        speed_100 = 1'b0; sqe_inhibit = 1'b1;
        for (int m = 0; m < 16; m++) begin
            @(negedge clk);
            full_duplex = m[0]; repeater_mode = m[1]; tx_en = m[2]; rx10_act = m[3];
            @(negedge clk);
            chk("R2_R7 col", col, !m[0] && m[2] && m[3]);
            if (!m[0] && !m[1]) chk("R8 crs", crs, m[2] | m[3]);
            else                chk("R9 crs", crs, m[3]);
        end
        @(negedge clk); tx_en = 1'b0; rx10_act = 1'b0; full_duplex = 1'b0; repeater_mode = 1'b0;

        // R3: at 100 Mb/s the 10 Mb/s flag is ignored.
        speed_100 = 1'b1;
        send('1);
        rx10_act = 1'b1; tx_en = 1'b1;
        @(negedge clk); @(negedge clk);
        chk("R3 col", col, 1'b0);
        chk("R3 crs", crs, 1'b1);
        rx10_act = 1'b0;

        // R13: unstrobed qualifying symbol is ignored.
        @(negedge clk); sym_valid = 1'b0; sym_data = '0;
        @(negedge clk); @(negedge clk);
        chk("R13 col", col, 1'b0);
        full_duplex = 1'b1;
        @(negedge clk); @(negedge clk);
        chk("R13 crs", crs, 1'b0);
        full_duplex = 1'b0;

        // R4 R5: every symbol from the idle state.
        for (int s = 0; s < 1024; s++) begin
            send('1);
            send(SW'(s));
            @(negedge clk);
            chk("R4_R5 set", col, qual(SW'(s)));
        end

        // R5 R6: every symbol from the active state.
        for (int s = 0; s < 1024; s++) begin
            send('0);
            send(SW'(s));
            @(negedge clk);
            chk("R5_R6 hold", col, (s != 1023));
        end
        send('1);
        @(negedge clk); tx_en = 1'b0;

        // R10: SQE pulse timing in 10 Mb/s half duplex.
        speed_100 = 1'b0; full_duplex = 1'b0; sqe_inhibit = 1'b0;
        repeat (2) @(negedge clk);
        sqe_window("R10", 1'b1);
        // R11: inhibited.
        sqe_inhibit = 1'b1;
        sqe_window("R11", 1'b0);
        // R12: 100 Mb/s and full duplex give no pulse.
        sqe_inhibit = 1'b0; speed_100 = 1'b1;
        sqe_window("R12 speed", 1'b0);
        speed_100 = 1'b0; full_duplex = 1'b1;
        sqe_window("R12 duplex", 1'b0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule